// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures the interval between qualifying transitions on up to four input pins, using one shared up-counter. Each pin has its own edge qualifier. When a qualifying transition is seen, the counter's present value goes into that pin's capture register. The counter then restarts from zero, and that channel's interrupt line pulses for one clock. Because every capture restarts the count, each stored value is the time since the previous capture on any channel.

The counter only advances on clocks where the count-clock strobe is high, and pin transitions are judged on those same clocks. Pins are synchronised through two flops before edge detection. If no qualifying transition arrives before the counter reaches its maximum, the next strobe wraps it to zero. That wrap pulses the overflow interrupt and sets a sticky overflow flag, which stays set until software clears it.

Software derives the width as the capture value plus 2^CW for each overflow seen, times the strobe period. With the enable low, the counter sits at zero and all interrupts stay quiet.

Top module: `pw_capture_timer`

## Requirements
- R1: While `rst_n` is low, every output is zero: capture data, capture interrupts, overflow interrupt and overflow flag.
- R2: While `run` is 1, the counter rises by one only on clocks where `cnt_en` is 1. On other clocks it holds and no interrupt is raised.
- R3: On a qualifying edge on channel m, three things happen at the same clock edge. The pre-edge count is written to capture slot m (`cap_data[m*CW +: CW]`), the counter becomes zero, and `cap_irq[m]` is high for exactly one clock.
- R4: Channel m's edge mode is `edge_sel[2m+1:2m]`: 2'b00 never captures, 2'b01 captures on low-to-high, 2'b10 on high-to-low, 2'b11 on either.
- R5: If several channels qualify on the same strobe, each of them stores the same count, and the counter is cleared only once.
- R6: A strobe that finds the counter at its maximum with no qualifying edge sets the counter to zero, pulses `ovf_irq` for one clock and sets `ovf_flag`.
- R7: `ovf_flag` stays set until `ovf_clr` is high at a clock edge. If a wrap and `ovf_clr` come at the same edge, the flag stays set.
- R8: With `run` at 0, the counter is held at zero, no interrupt is raised and pin transitions are not captured.
- R9: A pin change that is stable before clock edge k, with `cnt_en` high at edges k to k+2, raises its capture interrupt at edge k+2.
- R10: A qualifying edge on the strobe where the counter is at its maximum gives a capture of the maximum value and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable; 0 holds the counter at zero |
| cnt_en | input | 1 | Count-clock strobe; also the edge sampling strobe |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| cap_in | input | NCH | Capture input pins, asynchronous |
| edge_sel | input | 2*NCH | Per-channel edge mode, two bits per channel |
| cap_data | output | NCH*CW | Capture registers, channel m at bits m*CW +: CW |
| cap_irq | output | NCH | One-clock capture interrupt per channel |
| ovf_irq | output | 1 | One-clock overflow interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two collisions matter in this block. One is a capture landing on the same strobe as a counter wrap. The other is a software flag clear landing on the same edge as a new wrap. The bench runs a behavioural model alongside the design and uses it to find the clock where the counter holds its maximum. It then times a pin toggle so the synchronised edge arrives on exactly that strobe, and separately raises the clear on exactly that edge. It expects a capture of the maximum with no overflow in the first case, and a flag that stays set in the second. Simultaneous toggles on all four pins are checked the same way, for equal captured values and one clear of the counter.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/cap_edge_unit.sv
module cap_edge_unit
  import cap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);

  logic meta_q, sync_q, last_q;
  logic last_d;
  logic rise, fall;
  edge_mode_e sel;

  always_comb begin
    sel    = edge_mode_e'(mode);
    rise   = sync_q & ~last_q;
    fall   = ~sync_q & last_q;
    last_d = smp_en ? sync_q : last_q;
    hit    = 1'b0;
    if (smp_en) begin
      case (sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/cap_core.sv
module cap_core #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cnt_en,
  input  logic [NCH-1:0]    hit,
  input  logic              ovf_clr,
  output logic [NCH*CW-1:0] cap_data,
  output logic [NCH-1:0]    cap_irq,
  output logic              ovf_irq,
  output logic              ovf_flag
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  cap_q [NCH];
  logic [CW-1:0]  cap_d [NCH];
  logic [NCH-1:0] cirq_q, cirq_d;
  logic           oirq_q, oirq_d;
  logic           flag_q, flag_d;
  logic           any_hit;

  always_comb begin
    any_hit = |hit;
    cnt_d   = cnt_q;
    cirq_d  = '0;
    oirq_d  = 1'b0;
    for (int i = 0; i < NCH; i++) cap_d[i] = cap_q[i];
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      if (any_hit) begin
        cnt_d  = '0;
        cirq_d = hit;
        for (int i = 0; i < NCH; i++) if (hit[i]) cap_d[i] = cnt_q;
      end else if (cnt_q == CMAX) begin
        cnt_d  = '0;
        oirq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (oirq_d)       flag_d = 1'b1;
    else if (ovf_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cirq_q <= '0;
      oirq_q <= 1'b0;
      flag_q <= 1'b0;
      for (int i = 0; i < NCH; i++) cap_q[i] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cirq_q <= cirq_d;
      oirq_q <= oirq_d;
      flag_q <= flag_d;
      for (int i = 0; i < NCH; i++) cap_q[i] <= cap_d[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign cap_data[g*CW +: CW] = cap_q[g];
  end

  assign cap_irq  = cirq_q;
  assign ovf_irq  = oirq_q;
  assign ovf_flag = flag_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && cirq_q == '0 && !oirq_q)); // R8
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en) |=> ($stable(cnt_q) && cirq_q == '0 && !oirq_q)); // R2
  AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cirq_q) |-> (cnt_q == '0 && !oirq_q)); // R3
  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    oirq_q |-> (cnt_q == '0 && flag_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ovf_clr) |=> flag_q); // R7
  AST_CAPTURE_BEATS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && (|hit) && cnt_q == CMAX) |=> !oirq_q); // R10

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cirq_q[g] |-> (cap_q[g] == $past(cnt_q))); // R3
    if (g > 0) begin : g_same
      AST_SAME_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cirq_q[0] && cirq_q[g]) |-> (cap_q[0] == cap_q[g])); // R5
    end
  end

endmodule

// File: rtl/pw_capture_timer.sv
module pw_capture_timer #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cnt_en,
  input  logic              ovf_clr,
  input  logic [NCH-1:0]    cap_in,
  input  logic [2*NCH-1:0]  edge_sel,
  output logic [NCH*CW-1:0] cap_data,
  output logic [NCH-1:0]    cap_irq,
  output logic              ovf_irq,
  output logic              ovf_flag
);

  logic [NCH-1:0] hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cap_edge_unit u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (cnt_en),
      .pin    (cap_in[g]),
      .mode   (edge_sel[2*g +: 2]),
      .hit    (hit[g])
    );
  end

  cap_core #(.NCH(NCH), .CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cnt_en   (cnt_en),
    .hit      (hit),
    .ovf_clr  (ovf_clr),
    .cap_data (cap_data),
    .cap_irq  (cap_irq),
    .ovf_irq  (ovf_irq),
    .ovf_flag (ovf_flag)
  );

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_irq != '0) |-> $past(run && cnt_en)); // R8

endmodule

// File: tb/sim_pw_capture_timer.sv
module sim_pw_capture_timer;
  localparam int NCH  = 4;
  localparam int CW   = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run, cnt_en, ovf_clr;
  logic [NCH-1:0]    cap_in;
  logic [2*NCH-1:0]  edge_sel;
  logic [NCH*CW-1:0] cap_data;
  logic [NCH-1:0]    cap_irq;
  logic              ovf_irq, ovf_flag;

  pw_capture_timer #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cnt_en), .ovf_clr(ovf_clr),
    .cap_in(cap_in), .edge_sel(edge_sel), .cap_data(cap_data),
    .cap_irq(cap_irq), .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
  );

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference model
  int mcnt;
  int mcap [NCH];
  bit mcirq [NCH];
  bit movf, mflag;
  bit ms1 [NCH], ms2 [NCH], mprev [NCH];

  function automatic bit qualifies(int m, bit p, bit n);
    logic [1:0] md;
    md = edge_sel[2*m +: 2];
    return (md[0] && !p && n) || (md[1] && p && !n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit h [NCH];
    bit anyh;
    if (!rst_n) begin
      mcnt = 0; movf = 0; mflag = 0;
      for (int m = 0; m < NCH; m++) begin
        mcap[m] = 0; mcirq[m] = 0; ms1[m] = 0; ms2[m] = 0; mprev[m] = 0;
      end
    end else begin
      anyh = 0;
      movf = 0;
      for (int m = 0; m < NCH; m++) begin
        h[m] = cnt_en && qualifies(m, mprev[m], ms2[m]);
        anyh = anyh | h[m];
        mcirq[m] = 0;
      end
      if (!run) mcnt = 0;
      else if (cnt_en) begin
        if (anyh) begin
          for (int m = 0; m < NCH; m++)
            if (h[m]) begin mcap[m] = mcnt; mcirq[m] = 1; end
          mcnt = 0;
        end else if (mcnt == MAXV) begin
          mcnt = 0; movf = 1;
        end else mcnt++;
      end
      if (movf) mflag = 1;
      else if (ovf_clr) mflag = 0;
      for (int m = 0; m < NCH; m++) begin
        if (cnt_en) mprev[m] = ms2[m];
        ms2[m] = ms1[m];
        ms1[m] = cap_in[m];
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", req, tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < NCH; m++) begin
        chk(int'(cap_data[m*CW +: CW]) == mcap[m], "R3", $sformatf("cap_data ch%0d", m),
            int'(cap_data[m*CW +: CW]), mcap[m]);
        chk(cap_irq[m] == mcirq[m], "R3", $sformatf("cap_irq ch%0d", m),
            int'(cap_irq[m]), int'(mcirq[m]));
        if (cap_irq[0] && cap_irq[m])
          chk(cap_data[m*CW +: CW] == cap_data[CW-1:0], "R5", $sformatf("same value ch%0d", m),
              int'(cap_data[m*CW +: CW]), int'(cap_data[CW-1:0]));
      end
      chk(ovf_irq == movf, "R6", "ovf_irq", int'(ovf_irq), int'(movf));
      chk(ovf_flag == mflag, "R7", "ovf_flag", int'(ovf_flag), int'(mflag));
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog [%s] act=%0d exp=0", tag, cyc);
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit seen;
    rst_n = 0; run = 0; cnt_en = 0; ovf_clr = 0; cap_in = '0; edge_sel = '0;
    tick(3);
    chk(cap_data == '0, "R1", "reset cap_data", int'(cap_data != '0), 0);
    chk(cap_irq == '0 && !ovf_irq, "R1", "reset irqs", int'(cap_irq) + int'(ovf_irq), 0);
    chk(!ovf_flag, "R1", "reset flag", int'(ovf_flag), 0);
    rst_n = 1;

    // R2 / R9: sparse strobe, channel 0 rising
    tag = "R2"; run = 1; edge_sel = 8'b0000_0001;
    for (int i = 0; i < 300; i++) begin
      cnt_en = (i % 3 == 0);
      if (i % 25 == 0) cap_in[0] = ~cap_in[0];
      tick(1);
    end

    // R3: continuous strobe
    tag = "R3"; cnt_en = 1;
    for (int i = 0; i < 200; i++) begin
      if (i % 40 == 0) cap_in[0] = ~cap_in[0];
      tick(1);
    end

    // R4: every mode on its own channel: ch3 both, ch2 fall, ch1 rise, ch0 off
    tag = "R4"; edge_sel = 8'b11_10_01_00;
    for (int i = 0; i < 500; i++) begin
      cnt_en = ($urandom % 2) == 0;
      if (i % 7 == 0) cap_in = NCH'($urandom);
      tick(1);
    end

    // R5 / R9: all channels toggle together, latency checked explicitly
    tag = "R5"; edge_sel = 8'hFF; cnt_en = 1; tick(5);
    for (int k = 0; k < 4; k++) begin
      tick(20);
      cap_in = ~cap_in;
      tick(1);
      chk(cap_irq == '0, "R9", "irq too early (1)", int'(cap_irq), 0);
      tick(1);
      chk(cap_irq == '0, "R9", "irq too early (2)", int'(cap_irq), 0);
      tick(1);
      chk(cap_irq == 4'hF, "R9", "irq at third edge", int'(cap_irq), 15);
    end

    // R6: let the counter wrap
    tag = "R6"; seen = 0;
    for (int i = 0; i < 1200 && !seen; i++) begin
      tick(1);
      if (ovf_irq) seen = 1;
    end
    chk(seen, "R6", "overflow pulse seen", int'(seen), 1);
    chk(ovf_flag, "R6", "flag after wrap", int'(ovf_flag), 1);

    // R7: clear, then clear colliding with a wrap
    tag = "R7"; ovf_clr = 1; tick(1); ovf_clr = 0;
    chk(!ovf_flag, "R7", "flag cleared", int'(ovf_flag), 0);
    while (mcnt != MAXV) tick(1);
    ovf_clr = 1; tick(1); ovf_clr = 0;
    chk(ovf_irq, "R7", "wrap on clear edge", int'(ovf_irq), 1);
    chk(ovf_flag, "R7", "set beats clear", int'(ovf_flag), 1);
    ovf_clr = 1; tick(1); ovf_clr = 0;

    // R10: edge qualifies exactly when the counter holds its maximum
    tag = "R10";
    while (mcnt != MAXV - 2) tick(1);
    cap_in[1] = ~cap_in[1];
    tick(3);
    chk(cap_irq == 4'b0010, "R10", "capture at max", int'(cap_irq), 2);
    chk(!ovf_irq, "R10", "no wrap on capture", int'(ovf_irq), 0);
    chk(int'(cap_data[CW +: CW]) == MAXV, "R10", "captured max",
        int'(cap_data[CW +: CW]), MAXV);

    // R8: run low ignores pins
    tag = "R8"; run = 0;
    for (int i = 0; i < 150; i++) begin
      cnt_en = ($urandom % 2) == 0;
      if (i % 5 == 0) cap_in = NCH'($urandom);
      tick(1);
      chk(cap_irq == '0 && !ovf_irq, "R8", "irq while stopped",
          int'(cap_irq) + int'(ovf_irq), 0);
    end
    run = 1; cnt_en = 1;
    for (int i = 0; i < 100; i++) begin
      if (i % 30 == 0) cap_in = ~cap_in;
      tick(1);
    end

    summary();
  end

endmodule